// File: doc/BRIEF.md
# Frame-Tagged Pixel Queue with Alignment Check

This block is a synchronous queue that sits between a frame-buffer fetch engine and a real-time pixel output stage. Every word the fetch engine writes carries two tag bits beside the pixel data. One bit marks the first word of a frame and the other marks the last word. The fetch engine must watch the full flag, because a write into a full queue is dropped.

The output stage asks for one pixel per cycle with a request strobe and cannot be stalled. Each request ends in exactly one of the following outcomes, reported one cycle later:
- A pixel is delivered.
- An underflow is flagged, because the queue held nothing.
- A loss of frame alignment is flagged.
- A stray word is silently discarded while the reader searches for the next frame start.

The reader expects a frame start after reset and after every word tagged as a frame end. When the word read at that point lacks the start tag, the reader flags the loss and drops that word. It keeps dropping words until a start-tagged word arrives, and normal output resumes with that word.

Top module: `pxq_frame_fifo`

## Requirements
- R1: While reset is held and on the first cycle after it, `pix_valid`, `underflow` and `sync_lost` are 0, `pix_data` is 0 and `wr_full` is 0.
- R2: `wr_full` is 1 exactly when 2^ADDR_W words are stored. A write presented while `wr_full` is 1 is dropped, even when a read is accepted in the same cycle, and the dropped word is never delivered.
- R3: Words are delivered in write order. A delivered word appears on `pix_data`, with `pix_valid` high for one cycle, in the cycle after its request.
- R4: A request made while the queue is empty gives `underflow`=1 and `pix_valid`=0 in the next cycle. `pix_data` keeps its value and no word is consumed. A word written in the same cycle as such a request is not visible to that request and is delivered by a later request.
- R5: The first word read after reset, or after a word tagged frame-end, must carry the frame-start tag. If it does not, `sync_lost` pulses in the next cycle, that word is dropped, `pix_valid` stays 0 and `pix_data` holds.
- R6: After a sync loss, each request that finds a word without the frame-start tag drops it with no output pulse at all. A request that finds the queue empty flags `underflow`. The first start-tagged word is delivered normally, and checking resumes from it.
- R7: Inside a frame, a word that carries the frame-start tag is delivered like any other word and raises no flag.
- R8: `pix_valid`, `underflow` and `sync_lost` are mutually exclusive single-cycle pulses, and none of them is raised in a cycle after a cycle with no request.
- R9: When the queue is neither full nor empty, a write and a read in the same cycle both take effect, and the stored count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from the fetch engine |
| wr_data | input | DATA_W | Pixel word to store |
| wr_sof | input | 1 | Word is the first of a frame |
| wr_eof | input | 1 | Word is the last of a frame |
| wr_full | output | 1 | Queue holds 2^ADDR_W words; writes are dropped |
| rd_req | input | 1 | Output stage needs a pixel this cycle |
| pix_data | output | DATA_W | Last delivered pixel |
| pix_valid | output | 1 | One-cycle pulse: a pixel was delivered |
| underflow | output | 1 | One-cycle pulse: request found the queue empty |
| sync_lost | output | 1 | One-cycle pulse: frame start missing where expected |

## Verification
The hardest state to reach from the ports is the search state after an alignment loss, especially when it meets an empty queue. In that case the flag must switch from alignment loss to underflow, and the search must continue without raising a second loss. The stimulus gets there by first closing a clean frame with an end tag. It then writes untagged words and requests them one at a time. It checks the silent drops, the held pixel, the underflow on the emptied queue, and the recovery on a start-tagged word.

// File: rtl/pxq_pkg.sv
package pxq_pkg;

  typedef struct packed {
    logic sof;
    logic eof;
  } pxq_tag_t;

  typedef enum logic [1:0] {
    PXQ_ST_START = 2'd0,
    PXQ_ST_FRAME = 2'd1,
    PXQ_ST_HUNT  = 2'd2
  } pxq_state_e;

  typedef enum logic [2:0] {
    PXQ_ACT_NONE  = 3'd0,
    PXQ_ACT_EMIT  = 3'd1,
    PXQ_ACT_UNDER = 3'd2,
    PXQ_ACT_SYNC  = 3'd3,
    PXQ_ACT_DROP  = 3'd4
  } pxq_act_e;

  // What a request does, given the reader state and the word at the head.
  function automatic pxq_act_e pxq_decide(input pxq_state_e st, input logic req,
                                          input logic empty, input logic sof);
    pxq_act_e a;
    if (!req)        a = PXQ_ACT_NONE;
    else if (empty)  a = PXQ_ACT_UNDER;
    else begin
      unique case (st)
        PXQ_ST_START: a = sof ? PXQ_ACT_EMIT : PXQ_ACT_SYNC;
        PXQ_ST_HUNT:  a = sof ? PXQ_ACT_EMIT : PXQ_ACT_DROP;
        default:      a = PXQ_ACT_EMIT;
      endcase
    end
    return a;
  endfunction

  // Reader state after an action; a delivered frame-end word rearms the check.
  function automatic pxq_state_e pxq_advance(input pxq_state_e st, input pxq_act_e a,
                                             input logic eof);
    pxq_state_e n;
    unique case (a)
      PXQ_ACT_EMIT: n = eof ? PXQ_ST_START : PXQ_ST_FRAME;
      PXQ_ACT_SYNC,
      PXQ_ACT_DROP: n = PXQ_ST_HUNT;
      default:      n = st;
    endcase
    return n;
  endfunction

  function automatic logic pxq_consumes(input pxq_act_e a);
    return (a == PXQ_ACT_EMIT) || (a == PXQ_ACT_SYNC) || (a == PXQ_ACT_DROP);
  endfunction

endpackage

// File: rtl/pxq_ptr.sv
module pxq_ptr #(
  parameter int ADDR_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  output logic [ADDR_W:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/pxq_mem.sv
module pxq_mem #(
  parameter int WORD_W = 18,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int SLOTS = 1 << ADDR_W;

  logic [WORD_W-1:0] slot_q [SLOTS];

  always_ff @(posedge clk) begin
    if (we) slot_q[waddr] <= wdata;
  end

  assign rdata = slot_q[raddr];
endmodule

// File: rtl/pxq_reader.sv
module pxq_reader
  import pxq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              empty,
  input  logic [DATA_W-1:0] head_data,
  input  pxq_tag_t          head_tag,
  output logic              pop,
  output pxq_state_e        state,
  output logic [DATA_W-1:0] pix_data,
  output logic              pix_valid,
  output logic              underflow,
  output logic              sync_lost
);
  pxq_act_e   act;
  pxq_state_e state_d;

  always_comb begin
    act     = pxq_decide(state, rd_req, empty, head_tag.sof);
    state_d = pxq_advance(state, act, head_tag.eof);
  end

  assign pop = pxq_consumes(act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= PXQ_ST_START;
      pix_data  <= '0;
      pix_valid <= 1'b0;
      underflow <= 1'b0;
      sync_lost <= 1'b0;
    end else begin
      state     <= state_d;
      pix_valid <= (act == PXQ_ACT_EMIT);
      underflow <= (act == PXQ_ACT_UNDER);
      sync_lost <= (act == PXQ_ACT_SYNC);
      if (act == PXQ_ACT_EMIT) pix_data <= head_data;
    end
  end
endmodule

// File: rtl/pxq_frame_fifo.sv
module pxq_frame_fifo
  import pxq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_sof,
  input  logic              wr_eof,
  output logic              wr_full,
  input  logic              rd_req,
  output logic [DATA_W-1:0] pix_data,
  output logic              pix_valid,
  output logic              underflow,
  output logic              sync_lost
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int TAG_W  = $bits(pxq_tag_t);
  localparam int WORD_W = DATA_W + TAG_W;

  function automatic logic [ADDR_W:0] f_fill(input logic [ADDR_W:0] w, input logic [ADDR_W:0] r);
    return w - r;
  endfunction

  logic [ADDR_W:0]   wr_ptr, rd_ptr, fill;
  logic              full, empty, wr_accept, rd_pop;
  logic [WORD_W-1:0] head_word;
  logic [DATA_W-1:0] head_data;
  pxq_tag_t          head_tag, wr_tag;
  logic              head_sof;
  pxq_state_e        rd_state;

  assign fill      = f_fill(wr_ptr, rd_ptr);
  assign full      = (fill == (ADDR_W + 1)'(DEPTH));
  assign empty     = (wr_ptr == rd_ptr);
  assign wr_accept = wr_en && !full;
  assign wr_full   = full;
  assign wr_tag    = '{sof: wr_sof, eof: wr_eof};

  pxq_ptr #(.ADDR_W(ADDR_W)) u_wptr (.clk(clk), .rst_n(rst_n), .adv(wr_accept), .ptr(wr_ptr));
  pxq_ptr #(.ADDR_W(ADDR_W)) u_rptr (.clk(clk), .rst_n(rst_n), .adv(rd_pop),    .ptr(rd_ptr));

  pxq_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (wr_accept),
    .waddr (wr_ptr[ADDR_W-1:0]),
    .wdata ({wr_tag, wr_data}),
    .raddr (rd_ptr[ADDR_W-1:0]),
    .rdata (head_word)
  );

  assign head_data = head_word[DATA_W-1:0];
  assign head_tag  = head_word[WORD_W-1:DATA_W];
  assign head_sof  = head_tag.sof;

  pxq_reader #(.DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .empty     (empty),
    .head_data (head_data),
    .head_tag  (head_tag),
    .pop       (rd_pop),
    .state     (rd_state),
    .pix_data  (pix_data),
    .pix_valid (pix_valid),
    .underflow (underflow),
    .sync_lost (sync_lost)
  );
endmodule

// File: rtl/pxq_frame_fifo_chk.sv
module pxq_frame_fifo_chk
  import pxq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_req,
  input logic              full,
  input logic              empty,
  input logic              rd_pop,
  input logic [ADDR_W:0]   fill,
  input logic [DATA_W-1:0] head_data,
  input logic              head_sof,
  input pxq_state_e        rd_state,
  input logic [DATA_W-1:0] pix_data,
  input logic              pix_valid,
  input logic              underflow,
  input logic              sync_lost
);
  localparam int DEPTH = 1 << ADDR_W;

  p_events_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pix_valid, underflow, sync_lost}));

  p_quiet_without_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !(pix_valid || underflow || sync_lost));

  p_underflow_on_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && empty |=> underflow && !pix_valid);

  p_underflow_holds_pixel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && empty |=> $stable(pix_data));

  p_fill_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= (ADDR_W + 1)'(DEPTH));

  p_full_ignores_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full && !rd_pop |=> full);

  p_missing_sof_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !empty && rd_state == PXQ_ST_START && !head_sof |=> sync_lost && $stable(pix_data));

  p_hunt_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !empty && rd_state == PXQ_ST_HUNT && !head_sof |=> !pix_valid && !sync_lost);

  p_emit_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !empty && (rd_state == PXQ_ST_FRAME || head_sof) |=> pix_valid && pix_data == $past(head_data));

  p_concurrent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !full && rd_req && !empty |=> fill == $past(fill));
endmodule

bind pxq_frame_fifo pxq_frame_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_req    (rd_req),
  .full      (full),
  .empty     (empty),
  .rd_pop    (rd_pop),
  .fill      (fill),
  .head_data (head_data),
  .head_sof  (head_sof),
  .rd_state  (rd_state),
  .pix_data  (pix_data),
  .pix_valid (pix_valid),
  .underflow (underflow),
  .sync_lost (sync_lost)
);

// File: tb/test_pxq_frame_fifo.sv
module test_pxq_frame_fifo;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sof = 1'b0, wr_eof = 1'b0, rd_req = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic wr_full, pix_valid, underflow, sync_lost;
  logic [DW-1:0] pix_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] last_pix = '0;

  always #2 clk = ~clk;

  pxq_frame_fifo #(.DATA_W(DW), .ADDR_W(AW)) i_pxq_frame_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_sof(wr_sof),
    .wr_eof(wr_eof), .wr_full(wr_full), .rd_req(rd_req), .pix_data(pix_data),
    .pix_valid(pix_valid), .underflow(underflow), .sync_lost(sync_lost)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus; returns at the next falling edge with outputs settled.
  task automatic step(input logic we, input logic [DW-1:0] d, input logic s,
                      input logic e, input logic rq);
    wr_en = we; wr_data = d; wr_sof = s; wr_eof = e; rd_req = rq;
    @(negedge clk);
    wr_en = 1'b0; rd_req = 1'b0; wr_sof = 1'b0; wr_eof = 1'b0;
  endtask

  // kind: 0 quiet, 1 pixel, 2 underflow, 3 sync lost
  task automatic expect_out(input string req, input int kind, input logic [DW-1:0] d);
    chk(req, "pix_valid", int'(pix_valid), int'(kind == 1));
    chk(req, "underflow", int'(underflow), int'(kind == 2));
    chk(req, "sync_lost", int'(sync_lost), int'(kind == 3));
    if (kind == 1) last_pix = d;
    chk(req, "pix_data", int'(pix_data), int'(last_pix));
  endtask

  function automatic logic [DW-1:0] sweep_word(input int len, input int idx);
    return DW'((len << 4) + idx);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_out("R1", 0, '0);
    chk("R1", "wr_full", int'(wr_full), 0);

    // R4 underflow on empty, then R8 quiet cycle
    step(0, '0, 0, 0, 1);
    expect_out("R4", 2, '0);
    step(0, '0, 0, 0, 0);
    expect_out("R8", 0, '0);

    // R4 same-cycle write on empty queue is not visible to the request
    step(1, 8'hA5, 1, 1, 1);
    expect_out("R4", 2, '0);
    step(0, '0, 0, 0, 1);
    expect_out("R4", 1, 8'hA5);

    // R2 fill to the limit
    for (int i = 0; i < DEPTH; i++) begin
      step(1, DW'(8'h10 + i), i == 0, i == DEPTH - 1, 0);
      chk("R2", "wr_full", int'(wr_full), int'(i == DEPTH - 1));
    end
    // R2 write while full with a read in the same cycle: write dropped
    step(1, 8'hEE, 1, 1, 1);
    expect_out("R2", 1, 8'h10);
    chk("R2", "wr_full", int'(wr_full), 0);
    for (int i = 1; i < DEPTH; i++) begin
      step(0, '0, 0, 0, 1);
      expect_out("R3", 1, DW'(8'h10 + i));
    end
    step(0, '0, 0, 0, 1);
    expect_out("R2", 2, '0);

    // R3 / R9 sweep over frame lengths with concurrent write and read
    for (int len = 1; len <= DEPTH; len++) begin
      for (int i = 0; i < len; i++) begin
        step(1, sweep_word(len, i), i == 0, i == len - 1, i > 0);
        if (i > 0) expect_out("R9", 1, sweep_word(len, i - 1));
        else       expect_out("R3", 0, '0);
      end
      step(0, '0, 0, 0, 1);
      expect_out("R3", 1, sweep_word(len, len - 1));
    end

    // R7 start tag inside a frame is delivered normally
    for (int i = 0; i < 4; i++) step(1, DW'(8'h20 + i), i == 0 || i == 2, i == 3, 0);
    for (int i = 0; i < 4; i++) begin
      step(0, '0, 0, 0, 1);
      expect_out("R7", 1, DW'(8'h20 + i));
    end

    // R5 missing start, R6 silent discard, then recovery
    step(1, 8'h31, 0, 0, 0);
    step(1, 8'h32, 0, 0, 0);
    step(1, 8'h33, 1, 0, 0);
    step(1, 8'h34, 0, 1, 0);
    step(0, '0, 0, 0, 1);
    expect_out("R5", 3, '0);
    step(0, '0, 0, 0, 1);
    expect_out("R6", 0, '0);
    step(0, '0, 0, 0, 1);
    expect_out("R6", 1, 8'h33);
    step(0, '0, 0, 0, 1);
    expect_out("R6", 1, 8'h34);

    // R6 empty queue during the search, then more stray words
    step(1, 8'h41, 0, 0, 0);
    step(0, '0, 0, 0, 1);
    expect_out("R5", 3, '0);
    step(0, '0, 0, 0, 1);
    expect_out("R6", 2, '0);
    step(1, 8'h42, 0, 0, 0);
    step(0, '0, 0, 0, 1);
    expect_out("R6", 0, '0);
    step(1, 8'h43, 1, 1, 0);
    step(0, '0, 0, 0, 1);
    expect_out("R6", 1, 8'h43);

    // R5 frame-end-only word where a start is expected
    step(1, 8'h51, 0, 1, 0);
    step(0, '0, 0, 0, 1);
    expect_out("R5", 3, '0);
    step(0, '0, 0, 0, 0);
    expect_out("R8", 0, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule